// File: doc/BRIEF.md
# Test Wrapper Boundary Register Chain

This block surrounds a core's functional inputs and outputs with a serial chain of boundary cells so that the core can be tested in isolation. There are two kinds of test. In core test, stimulus is driven into the core from the input-side cells and the core's responses are observed by the output-side cells. In external test, the outside pins are observed by the input-side cells and the outside logic is driven from the output-side cells. When test mode is off, every cell is transparent and functional data flows straight through.

One wrapper scan enable shifts the whole chain. A capture request loads the cells of the side that observes in the current mode. When neither shifting nor capturing is active, every cell keeps its value. Because of this, repeated capture cycles never expose undefined data at the boundary. Both sides use one control decoder. The only difference between the two instances is that the two mode bits are connected the other way round.

Top module: `wbr_chain`

## Requirements
- R1: With `test_mode` low, `core_in` equals `pin_in` and `pin_out` equals `core_out`, and no cell changes, whatever the other controls do.
- R2: With `test_mode` and `wse` high, the chain advances one position per clock. The order is `wsi`, then input cells 0 to N_IN-1, then output cells 0 to N_OUT-1. `wso` is output cell N_OUT-1, so the first bit shifted in is the first to appear on `wso`.
- R3: With `test_mode` high, `wse` low and no capture taking effect, every cell keeps its value for any number of cycles.
- R4: External-test capture loads `pin_in[i]` into input cell i and leaves the output cells unchanged. It happens when `test_mode`=1, `wextest`=1, `wintest`=0, `wse`=0 and `cap_req`=1.
- R5: Core-test capture loads `core_out[j]` into output cell j and leaves the input cells unchanged. It happens when `test_mode`=1, `wintest`=1, `wextest`=0, `wse`=0 and `cap_req`=1.
- R6: In external test, `pin_out` shows the output cells and `core_in` equals `pin_in`. In core test, `core_in` shows the input cells and `pin_out` equals `core_out`.
- R7: When `wse` and `cap_req` are high in the same cycle, the chain shifts and no cell captures.
- R8: With `wintest` and `wextest` both high, neither side captures or drives, and both sides pass through. Shifting still works.
- R9: Reset (`rst_n` low, asynchronous) clears every cell to 0, so `wso` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test and functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | Enables wrapper operation; low means transparent |
| wse | input | 1 | Single wrapper scan enable for the whole chain |
| wintest | input | 1 | Core-test mode select |
| wextest | input | 1 | External-test mode select |
| cap_req | input | 1 | Capture request |
| wsi | input | 1 | Serial data into input cell 0 |
| pin_in | input | N_IN | Functional inputs from outside the core |
| core_in | output | N_IN | Functional inputs delivered to the core |
| core_out | input | N_OUT | Functional outputs produced by the core |
| pin_out | output | N_OUT | Functional outputs delivered outside |
| wso | output | 1 | Serial data from the last output cell |

## Verification
A shift and a capture can be requested in the same cycle. The bench provokes this with directed cycles in which `wse` and `cap_req` are both high under each test mode, and the random phase raises them together often. In those cycles the outcome is judged against a bench model in which shifting always wins, by comparing `wso`, `core_in` and `pin_out` on every cycle. A later shift-out then shows that no captured bit slipped into the chain.

// File: rtl/wbr_pkg.sv
package wbr_pkg;
    typedef struct packed {
        logic shift;      // advance the serial chain
        logic capture_n;  // active-low load from the observed side
        logic drive;      // cells drive the functional output of this side
    } side_ctrl_t;
endpackage

// File: rtl/wbr_side_ctrl.sv
module wbr_side_ctrl
    import wbr_pkg::*;
#(
    parameter bit IS_INPUT = 1'b1
) (
    input  logic       test_mode,
    input  logic       wse,
    input  logic       wintest,
    input  logic       wextest,
    input  logic       cap_req,
    output side_ctrl_t ctrl
);
    logic observe_sel;
    logic drive_sel;

    // The two sides share this decoder; only the mode wiring is swapped.
    generate
        if (IS_INPUT) begin : g_input_side
            assign observe_sel = wextest;
            assign drive_sel   = wintest;
        end else begin : g_output_side
            assign observe_sel = wintest;
            assign drive_sel   = wextest;
        end
    endgenerate

    always_comb begin
        ctrl.shift     = test_mode & wse;
        ctrl.capture_n = ~(test_mode & ~wse & cap_req & observe_sel & ~drive_sel);
        ctrl.drive     = test_mode & drive_sel & ~observe_sel;
    end
endmodule

// File: rtl/wbr_cell_bank.sv
module wbr_cell_bank
    import wbr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  side_ctrl_t       ctrl,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] func_in,
    output logic [WIDTH-1:0] func_out,
    output logic             ser_out
);
    localparam int LAST = WIDTH - 1;

    logic [WIDTH-1:0] cells_d;
    logic [WIDTH-1:0] cells_q;

    always_comb begin
        cells_d = cells_q;                       // hold path
        if (ctrl.shift) begin
            for (int i = LAST; i > 0; i--) begin
                cells_d[i] = cells_q[i-1];
            end
            cells_d[0] = ser_in;
        end else if (!ctrl.capture_n) begin
            cells_d = func_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cells_q <= '0;
        end else begin
            cells_q <= cells_d;
        end
    end

    assign func_out = ctrl.drive ? cells_q : func_in;
    assign ser_out  = cells_q[LAST];

    // R3: no shift and no capture keeps every cell
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.shift && ctrl.capture_n) |=> $stable(cells_q));

    // R2: the first cell takes the serial input on a shift
    p_shift_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.shift |=> (cells_q[0] == $past(ser_in)));

    // R4 / R5: a capture loads the functional side
    p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.shift && !ctrl.capture_n) |=> (cells_q == $past(func_in)));

    generate
        if (WIDTH > 1) begin : g_shift_body
            // R2: every later cell takes its neighbour
            p_shift_body_r2: assert property (@(posedge clk) disable iff (!rst_n)
                ctrl.shift |=> (cells_q[LAST:1] == $past(cells_q[LAST-1:0])));
        end
    endgenerate
endmodule

// File: rtl/wbr_chain.sv
module wbr_chain
    import wbr_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_OUT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             test_mode,
    input  logic             wse,
    input  logic             wintest,
    input  logic             wextest,
    input  logic             cap_req,
    input  logic             wsi,
    input  logic [N_IN-1:0]  pin_in,
    output logic [N_IN-1:0]  core_in,
    input  logic [N_OUT-1:0] core_out,
    output logic [N_OUT-1:0] pin_out,
    output logic             wso
);
    side_ctrl_t in_ctl;
    side_ctrl_t out_ctl;
    logic       link;   // last input cell to first output cell

    wbr_side_ctrl #(.IS_INPUT(1'b1)) u_in_ctl (
        .test_mode (test_mode),
        .wse       (wse),
        .wintest   (wintest),
        .wextest   (wextest),
        .cap_req   (cap_req),
        .ctrl      (in_ctl)
    );

    wbr_side_ctrl #(.IS_INPUT(1'b0)) u_out_ctl (
        .test_mode (test_mode),
        .wse       (wse),
        .wintest   (wintest),
        .wextest   (wextest),
        .cap_req   (cap_req),
        .ctrl      (out_ctl)
    );

    wbr_cell_bank #(.WIDTH(N_IN)) u_in_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl     (in_ctl),
        .ser_in   (wsi),
        .func_in  (pin_in),
        .func_out (core_in),
        .ser_out  (link)
    );

    wbr_cell_bank #(.WIDTH(N_OUT)) u_out_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl     (out_ctl),
        .ser_in   (link),
        .func_in  (core_out),
        .func_out (pin_out),
        .ser_out  (wso)
    );

    // R1: transparent outside test mode
    p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |-> (core_in == pin_in && pin_out == core_out));

    // R2: one scan enable reaches both sides alike
    p_single_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_ctl.shift == out_ctl.shift);

    // R7: shifting suppresses capture on both sides
    p_shift_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wse |-> (in_ctl.capture_n && out_ctl.capture_n));

    // R8: conflicting modes give neither capture nor drive
    p_mode_clash_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wintest && wextest) |-> (in_ctl.capture_n && out_ctl.capture_n &&
                                  !in_ctl.drive && !out_ctl.drive));

    // R6: the two sides never drive at once
    p_one_driver_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ctl.drive && out_ctl.drive));
endmodule

// File: tb/wbr_chain_tb_top.sv
module wbr_chain_tb_top;
    localparam int NI = 4;
    localparam int NO = 3;
    localparam int NT = NI + NO;

    logic clk = 1'b0;
    logic rst_n;
    logic test_mode, wse, wintest, wextest, cap_req, wsi;
    logic [NI-1:0] pin_in;
    logic [NI-1:0] core_in;
    logic [NO-1:0] core_out;
    logic [NO-1:0] pin_out;
    logic wso;

    logic [NT-1:0] m;   // bench model: bits [NI-1:0] input cells, then output cells
    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;   // 50 MHz

    wbr_chain #(.N_IN(NI), .N_OUT(NO)) dut_i (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .wse(wse),
        .wintest(wintest), .wextest(wextest), .cap_req(cap_req), .wsi(wsi),
        .pin_in(pin_in), .core_in(core_in), .core_out(core_out),
        .pin_out(pin_out), .wso(wso)
    );

    function automatic logic [NI-1:0] exp_core_in();
        return (test_mode && wintest && !wextest) ? m[NI-1:0] : pin_in;
    endfunction

    function automatic logic [NO-1:0] exp_pin_out();
        return (test_mode && wextest && !wintest) ? m[NT-1:NI] : core_out;
    endfunction

    function automatic logic [NT-1:0] exp_next();
        logic [NT-1:0] n = m;
        if (test_mode && wse)
            n = {m[NT-2:0], wsi};
        else if (test_mode && cap_req && wextest && !wintest)
            n[NI-1:0] = pin_in;
        else if (test_mode && cap_req && wintest && !wextest)
            n[NT-1:NI] = core_out;
        return n;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_in(logic tm, logic se, logic wi, logic we, logic cp, logic si,
                          logic [NI-1:0] pi, logic [NO-1:0] co);
        test_mode = tm; wse = se; wintest = wi; wextest = we;
        cap_req = cp; wsi = si; pin_in = pi; core_out = co;
    endtask

    // Called at a falling edge with inputs set; checks outputs, then one clock.
    task automatic step(string req);
        logic [NT-1:0] nxt;
        #2;
        chk(req, "core_in", 32'(core_in), 32'(exp_core_in()));
        chk(req, "pin_out", 32'(pin_out), 32'(exp_pin_out()));
        chk(req, "wso",     32'(wso),     32'(m[NT-1]));
        nxt = exp_next();
        @(posedge clk);
        #1 m = nxt;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [NT-1:0] pat;
        logic [NI-1:0] cap_pins;
        void'($urandom(32'd1500));
        m = '0;
        rst_n = 1'b0;
        set_in(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
        @(negedge clk);
        @(negedge clk);
        #2 chk("R9", "wso in reset", 32'(wso), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: core test drives the reset contents (all zero) into the core
        set_in(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'hF, 3'h5);
        step("R9");

        // R1: transparency with random other controls
        for (int k = 0; k < 12; k++) begin
            set_in(1'b0, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                   1'($urandom), NI'($urandom), NO'($urandom));
            step("R1");
        end

        // R2 then R3: shift a pattern in, hold it, shift it out
        pat = 7'b1011001;
        for (int k = 0; k < NT; k++) begin
            set_in(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, pat[k], NI'($urandom), NO'($urandom));
            step("R2");
        end
        for (int k = 0; k < 20; k++) begin
            set_in(1'b1, 1'b0, 1'($urandom), 1'($urandom), 1'b0, 1'($urandom),
                   NI'($urandom), NO'($urandom));
            step("R3");
        end
        for (int k = 0; k < NT; k++) begin
            set_in(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
            #1 chk("R3", "held bit on wso", 32'(wso), 32'(pat[k]));
            #0 step("R2");
        end

        // R4 and R6: external-test capture, then shift the captured bits out
        cap_pins = 4'b1101;
        set_in(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, cap_pins, 3'b010);
        step("R4");
        set_in(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0110, 3'b001);
        step("R6");
        for (int k = 0; k < NT; k++) begin
            set_in(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, '0, '0);
            if (k >= NO) begin
                #1 chk("R4", "captured pin on wso", 32'(wso), 32'(cap_pins[NI-1-(k-NO)]));
            end
            step("R2");
        end

        // R5: core-test capture, last output cell appears on wso at once
        set_in(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'b1010, 3'b101);
        step("R5");
        set_in(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0101, 3'b000);
        #1 chk("R5", "wso after capture", 32'(wso), 32'd1);
        step("R6");

        // R7: shift and capture together under both modes
        set_in(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 3'h7);
        step("R7");
        set_in(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'hF, 3'h7);
        step("R7");

        // R8: both mode bits high: no capture, no drive, shifting still works
        for (int k = 0; k < 6; k++) begin
            set_in(1'b1, 1'(k[0]), 1'b1, 1'b1, 1'b1, 1'($urandom),
                   NI'($urandom), NO'($urandom));
            step("R8");
        end

        // Random mix of all controls against the model
        for (int k = 0; k < 400; k++) begin
            set_in(($urandom % 8) != 0, 1'($urandom), 1'($urandom), 1'($urandom),
                   1'($urandom), 1'($urandom), NI'($urandom), NO'($urandom));
            step("R2/R4/R5/R6/R7 random");
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule